// File: doc/BRIEF.md
# Low-Power Watch Mode Sequencer

This block decides which power mode a small microcontroller is in and drives the clock enables that follow from it. The modes are full-speed run, divided-speed run, sub-clock run, the low-power watch state and hardware standby. The CPU asks to sleep. The block enters the watch state only when a fixed set of static control bits agree and the system clock divider is set to zero. In that state only the always-on watch group (watchdog, one timer and the display driver) keeps its clock, and the A/D converter is held in reset.

Any enabled wake source that the CPU does not mask ends the watch state. There are fourteen sources: bit 0 is the watchdog overflow, bit 1 is the NMI pin, bits 2 to 5 are external IRQ lines and bits 6 to 13 are wake-up pins. The mask has no effect on NMI. What follows a wake depends on the sub-clock select bit and the divider field:

- With the sub-clock select bit set, the block moves to sub-clock run after a fixed two-cycle delay.
- With the bit clear and a nonzero divider, it returns to divided-speed run at once.
- Otherwise it returns to full speed, but only after a programmable oscillator settling count.

Each of these paths ends with a one-cycle pulse that starts interrupt exception processing. A low standby pin overrides everything, and only reset leaves hardware standby.

Top module: `pwr_watch_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, mode_o is 0 (full speed). In that state cpu_ce_o, per_ce_o and watch_ce_o are 1, and adc_rst_o and exc_start_o are 0.
- R2: Mode codes are 0 full speed, 1 divided speed, 2 sub-clock run, 3 watch and 4 hardware standby. Watch mode is entered one clock after sleep_req_i is sampled high in mode 0 or 2, provided ssby_i=1, dton_i=0, pss_i=1 and clkdiv_i=0. In watch mode cpu_ce_o=0, per_ce_o=0, watch_ce_o=1 and adc_rst_o=1.
- R3: A sleep request is ignored and the mode is kept in two cases: when any of ssby_i, dton_i, pss_i or clkdiv_i differs from the entry combination, and when the current mode is 1.
- R4: In watch mode, a wake_req_i bit whose wake_en_i bit is 1 ends the watch state when cpu_mask_i is 0. For bit 1 (NMI) this holds whatever the value of cpu_mask_i.
- R5: A wake request whose enable bit is 0 does not end watch mode. Neither does a request on a non-NMI bit while cpu_mask_i=1. The mode stays 3 with the watch clocks unchanged.
- R6: When a wake is sampled with lson_i=0 and clkdiv_i=0, mode_o stays 3 and the clocks stay gated for N = 8 << settle_sel_i cycles. In the next cycle mode_o becomes 0 and exc_start_o is 1, so exc_start_o is first seen N+1 clocks after the wake is sampled.
- R7: When a wake is sampled with lson_i=0 and clkdiv_i nonzero, mode_o becomes 1 and exc_start_o is 1 one clock later.
- R8: When a wake is sampled with lson_i=1, mode_o stays 3 for two cycles. Three clocks after the wake it becomes 2, with exc_start_o at 1.
- R9: When stby_n_i is sampled low, mode_o is 4 one clock later from any mode. In mode 4 all clock enables are 0 and adc_rst_o is 1. The block stays in mode 4 until reset, whatever stby_n_i or the wake inputs do.
- R10: exc_start_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the settling reference |
| rst | input | 1 | Synchronous active-high reset pin |
| stby_n_i | input | 1 | Active-low hardware standby pin |
| sleep_req_i | input | 1 | Sleep request from the CPU |
| ssby_i | input | 1 | Standby-select control bit |
| dton_i | input | 1 | Direct-transfer control bit |
| pss_i | input | 1 | Watchdog prescaler-select bit |
| lson_i | input | 1 | Sub-clock select for the wake target |
| clkdiv_i | input | 3 | System clock divider field |
| settle_sel_i | input | 3 | Settling time select |
| wake_req_i | input | 14 | Wake requests (bit 1 = NMI) |
| wake_en_i | input | 14 | Per-source enable / pin-function bits |
| cpu_mask_i | input | 1 | CPU interrupt mask (NMI exempt) |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | General peripheral clock enable |
| watch_ce_o | output | 1 | Watch-group clock enable |
| adc_rst_o | output | 1 | A/D converter reset |
| mode_o | output | 3 | Current mode code |
| exc_start_o | output | 1 | One-cycle exception-start pulse |

## Verification
Each output is registered from the next-state decision. Mode changes and clock enables therefore show up one clock after the input is sampled. The exception pulse arrives 1, 3 or N+1 clocks after the wake, depending on whether the block returns to divided speed, sub-clock run or full speed. The bench drives inputs on the falling edge and samples on the falling edge that follows the rising edge where the result is due. For the settling path it counts clocks until the pulse and compares the count with N+1 for two settle selections.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_HIGH   = 3'd0,
    ST_MED    = 3'd1,
    ST_SUB    = 3'd2,
    ST_WATCH  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_SUBDLY = 3'd5,
    ST_HSTBY  = 3'd6
  } pwr_state_t;

  localparam logic [2:0] MODE_HIGH  = 3'd0;
  localparam logic [2:0] MODE_MED   = 3'd1;
  localparam logic [2:0] MODE_SUB   = 3'd2;
  localparam logic [2:0] MODE_WATCH = 3'd3;
  localparam logic [2:0] MODE_HSTBY = 3'd4;

  typedef struct packed {
    logic       cpu_ce;
    logic       per_ce;
    logic       watch_ce;
    logic       adc_rst;
    logic [2:0] mode;
  } pwr_out_t;
endpackage

// File: rtl/pwr_entry_check.sv
module pwr_entry_check #(
  parameter int DIV_W = 3
) (
  input  logic             ssby_i,
  input  logic             dton_i,
  input  logic             pss_i,
  input  logic [DIV_W-1:0] clkdiv_i,
  output logic             entry_ok_o
);
  always_comb begin
    entry_ok_o = ssby_i && !dton_i && pss_i && (clkdiv_i == '0);
  end
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NWAKE   = 14,
  parameter int NMI_BIT = 1
) (
  input  logic [NWAKE-1:0] req_i,
  input  logic [NWAKE-1:0] en_i,
  input  logic             mask_i,
  output logic             hit_o
);
  logic [NWAKE-1:0] pass;

  for (genvar i = 0; i < NWAKE; i++) begin : g_src
    if (i == NMI_BIT) begin : g_nmi
      assign pass[i] = req_i[i] && en_i[i];
    end else begin : g_mskbl
      assign pass[i] = req_i[i] && en_i[i] && !mask_i;
    end
  end

  assign hit_o = |pass;
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= load_val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/pwr_watch_ctrl.sv
module pwr_watch_ctrl
  import pwr_pkg::*;
#(
  parameter int NWAKE       = 14,
  parameter int NMI_BIT     = 1,
  parameter int DIV_W       = 3,
  parameter int SEL_W       = 3,
  parameter int SETTLE_BASE = 8,
  parameter int SUB_DLY     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stby_n_i,
  input  logic             sleep_req_i,
  input  logic             ssby_i,
  input  logic             dton_i,
  input  logic             pss_i,
  input  logic             lson_i,
  input  logic [DIV_W-1:0] clkdiv_i,
  input  logic [SEL_W-1:0] settle_sel_i,
  input  logic [NWAKE-1:0] wake_req_i,
  input  logic [NWAKE-1:0] wake_en_i,
  input  logic             cpu_mask_i,
  output logic             cpu_ce_o,
  output logic             per_ce_o,
  output logic             watch_ce_o,
  output logic             adc_rst_o,
  output logic [2:0]       mode_o,
  output logic             exc_start_o
);
  localparam int MAX_SETTLE = SETTLE_BASE << ((1 << SEL_W) - 1);
  localparam int CW         = $clog2(MAX_SETTLE);

  pwr_state_t    st, nxt;
  logic          entry_ok, wake_hit, tmr_zero, tmr_load, exc_nxt;
  logic [CW-1:0] tmr_val, settle_val, base_val;
  pwr_out_t      dec;

  pwr_entry_check #(.DIV_W(DIV_W)) u_entry (
    .ssby_i     (ssby_i),
    .dton_i     (dton_i),
    .pss_i      (pss_i),
    .clkdiv_i   (clkdiv_i),
    .entry_ok_o (entry_ok)
  );

  pwr_wake_qual #(.NWAKE(NWAKE), .NMI_BIT(NMI_BIT)) u_wake (
    .req_i  (wake_req_i),
    .en_i   (wake_en_i),
    .mask_i (cpu_mask_i),
    .hit_o  (wake_hit)
  );

  pwr_settle_timer #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign base_val   = CW'(SETTLE_BASE);
  assign settle_val = (base_val << settle_sel_i) - CW'(1);

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = settle_val;
    if (!stby_n_i) begin
      nxt = ST_HSTBY;
    end else begin
      unique case (st)
        ST_HIGH, ST_SUB: if (sleep_req_i && entry_ok) nxt = ST_WATCH;
        ST_WATCH: begin
          if (wake_hit) begin
            if (lson_i) begin
              nxt      = ST_SUBDLY;
              tmr_load = 1'b1;
              tmr_val  = CW'(SUB_DLY - 1);
            end else if (clkdiv_i != '0) begin
              nxt = ST_MED;
            end else begin
              nxt      = ST_SETTLE;
              tmr_load = 1'b1;
            end
          end
        end
        ST_SETTLE: if (tmr_zero) nxt = ST_HIGH;
        ST_SUBDLY: if (tmr_zero) nxt = ST_SUB;
        default:   nxt = st;
      endcase
    end
  end

  assign exc_nxt = (st == ST_SETTLE && nxt == ST_HIGH) ||
                   (st == ST_SUBDLY && nxt == ST_SUB)  ||
                   (st == ST_WATCH  && nxt == ST_MED);

  always_comb begin
    unique case (nxt)
      ST_HIGH:  dec = '{1'b1, 1'b1, 1'b1, 1'b0, MODE_HIGH};
      ST_MED:   dec = '{1'b1, 1'b1, 1'b1, 1'b0, MODE_MED};
      ST_SUB:   dec = '{1'b1, 1'b1, 1'b1, 1'b0, MODE_SUB};
      ST_HSTBY: dec = '{1'b0, 1'b0, 1'b0, 1'b1, MODE_HSTBY};
      default:  dec = '{1'b0, 1'b0, 1'b1, 1'b1, MODE_WATCH};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_HIGH;
      cpu_ce_o    <= 1'b1;
      per_ce_o    <= 1'b1;
      watch_ce_o  <= 1'b1;
      adc_rst_o   <= 1'b0;
      mode_o      <= MODE_HIGH;
      exc_start_o <= 1'b0;
    end else begin
      st          <= nxt;
      cpu_ce_o    <= dec.cpu_ce;
      per_ce_o    <= dec.per_ce;
      watch_ce_o  <= dec.watch_ce;
      adc_rst_o   <= dec.adc_rst;
      mode_o      <= dec.mode;
      exc_start_o <= exc_nxt;
    end
  end
endmodule

// File: rtl/pwr_watch_ctrl_chk.sv
module pwr_watch_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stby_n_i,
  input logic       cpu_ce_o,
  input logic       per_ce_o,
  input logic       watch_ce_o,
  input logic       adc_rst_o,
  input logic [2:0] mode_o,
  input logic       exc_start_o
);
  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    exc_start_o |=> !exc_start_o); // R10

  AST_WATCH_GATES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> (!cpu_ce_o && !per_ce_o && watch_ce_o && adc_rst_o)); // R2

  AST_STBY_FORCE: assert property (@(posedge clk) disable iff (rst)
    !stby_n_i |=> (mode_o == 3'd4)); // R9

  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |=> (mode_o == 3'd4)); // R9

  AST_STBY_GATES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> (!cpu_ce_o && !per_ce_o && !watch_ce_o && adc_rst_o)); // R9

  AST_EXC_RUNNING: assert property (@(posedge clk) disable iff (rst)
    exc_start_o |-> (mode_o <= 3'd2 && cpu_ce_o)); // R6

  AST_MED_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1 && stby_n_i) |=> (mode_o == 3'd1)); // R3
endmodule

bind pwr_watch_ctrl pwr_watch_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .stby_n_i    (stby_n_i),
  .cpu_ce_o    (cpu_ce_o),
  .per_ce_o    (per_ce_o),
  .watch_ce_o  (watch_ce_o),
  .adc_rst_o   (adc_rst_o),
  .mode_o      (mode_o),
  .exc_start_o (exc_start_o)
);

// File: tb/pwr_watch_ctrl_test.sv
module pwr_watch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stby_n_i = 1'b1, sleep_req_i = 1'b0;
  logic        ssby_i = 1'b0, dton_i = 1'b0, pss_i = 1'b0, lson_i = 1'b0;
  logic [2:0]  clkdiv_i = '0, settle_sel_i = '0;
  logic [13:0] wake_req_i = '0, wake_en_i = '0;
  logic        cpu_mask_i = 1'b0;
  logic        cpu_ce_o, per_ce_o, watch_ce_o, adc_rst_o, exc_start_o;
  logic [2:0]  mode_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_watch_ctrl uut (.*);

  // [6] ssby  [5] dton  [4] pss  [3:1] clkdiv  [0] expect watch
  localparam logic [6:0] VECS [0:7] = '{
    7'b1_0_1_000_1, 7'b0_0_1_000_0, 7'b1_1_1_000_0, 7'b1_0_0_000_0,
    7'b1_0_1_001_0, 7'b1_0_1_100_0, 7'b0_0_0_000_0, 7'b1_0_1_010_0};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; stby_n_i = 1'b1; sleep_req_i = 1'b0; wake_req_i = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic enter_watch();
    ssby_i = 1'b1; dton_i = 1'b0; pss_i = 1'b1; clkdiv_i = '0;
    sleep_req_i = 1'b1; tick(); sleep_req_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    tick();
    // R1 reset state
    check("R1 mode", mode_o, 0);
    check("R1 clocks", {cpu_ce_o, per_ce_o, watch_ce_o}, 7);
    check("R1 adc/exc", {adc_rst_o, exc_start_o}, 0);

    // R2 / R3 entry combinations from table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      ssby_i = VECS[v][6]; dton_i = VECS[v][5]; pss_i = VECS[v][4];
      clkdiv_i = VECS[v][3:1];
      sleep_req_i = 1'b1; tick(); sleep_req_i = 1'b0;
      check(VECS[v][0] ? "R2 entry" : "R3 ignored", mode_o, VECS[v][0] ? 3 : 0);
    end

    // R2 gating in watch
    do_reset(); enter_watch();
    check("R2 gates", {cpu_ce_o, per_ce_o, watch_ce_o, adc_rst_o}, 4'b0011);

    // R5 disabled source and masked IRQ
    wake_req_i = 14'h0040; wake_en_i = '0; tick(); tick(); tick();
    check("R5 disabled", mode_o, 3);
    wake_req_i = 14'h0004; wake_en_i = 14'h0004; cpu_mask_i = 1'b1;
    tick(); tick(); tick();
    check("R5 masked", mode_o, 3);
    check("R5 watch clk", watch_ce_o, 1);

    // R4 NMI passes the mask; R6 settle 8 cycles
    lson_i = 1'b0; clkdiv_i = '0; settle_sel_i = 3'd0;
    wake_req_i = 14'h0002; wake_en_i = 14'h0002;
    tick(); wake_req_i = '0;
    for (int k = 2; k <= 8; k++) tick();
    check("R6 still gated", {mode_o, cpu_ce_o}, {3'd3, 1'b0});
    check("R6 no exc yet", exc_start_o, 0);
    tick();
    check("R4 NMI wake mode", mode_o, 0);
    check("R6 exc", exc_start_o, 1);
    tick();
    check("R10 exc drops", exc_start_o, 0);

    // R6 settle 32 cycles, unmasked IRQ
    cpu_mask_i = 1'b0; enter_watch(); settle_sel_i = 3'd2;
    wake_req_i = 14'h0008; wake_en_i = 14'h0008;
    begin
      int n = 0;
      while (!exc_start_o && n < 2000) begin
        tick(); n++; wake_req_i = '0;
      end
      check("R6 count sel2", n, 33);
      check("R4 IRQ wake mode", mode_o, 0);
    end

    // R8 sub-clock wake
    enter_watch(); lson_i = 1'b1;
    wake_req_i = 14'h0001; wake_en_i = 14'h0001;
    tick(); wake_req_i = '0; tick();
    check("R8 delay", {mode_o, exc_start_o}, {3'd3, 1'b0});
    tick();
    check("R8 sub", {mode_o, exc_start_o}, {3'd2, 1'b1});
    // R2 entry from sub-clock run
    enter_watch();
    check("R2 from sub", mode_o, 3);

    // R7 divided-speed wake, then R3 sleep ignored in mode 1
    lson_i = 1'b0; clkdiv_i = 3'd3;
    wake_req_i = 14'h2000; wake_en_i = 14'h2000;
    tick(); wake_req_i = '0;
    check("R7 med", {mode_o, exc_start_o}, {3'd1, 1'b1});
    enter_watch(); tick();
    check("R3 no sleep from med", mode_o, 1);

    // R9 standby during settle, held until reset
    clkdiv_i = '0; do_reset(); enter_watch(); settle_sel_i = 3'd7;
    wake_req_i = 14'h0002; wake_en_i = 14'h0002; tick(); wake_req_i = '0;
    tick(); stby_n_i = 1'b0; tick();
    check("R9 standby", mode_o, 4);
    check("R9 gates", {cpu_ce_o, per_ce_o, watch_ce_o, adc_rst_o}, 4'b0001);
    stby_n_i = 1'b1; wake_req_i = 14'h0002; tick(); tick(); tick();
    check("R9 held", mode_o, 4);
    do_reset(); tick();
    check("R1 after standby", mode_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule